// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block models the tag side of a set-associative cache. It holds no data. For every address it accepts, it reports whether the line is present and which way holds the line, or which way now receives it. The address is cut into a block offset, a set index and a tag. The indexed set is searched. On a miss a way is claimed in the same access, so a repeat of the address hits.

The replacement policy is selected through a configuration input. Three policies are available: least-recently-used, using per-set generation stamps; first-in-first-out, by fill order; and pseudo-random, drawn from a free-running LFSR. Empty ways are always filled before the policy is consulted. Two running counters record the accesses and the misses.

Typical use is performance modelling, or as the lookup front end of a cache controller. The configuration input should only be changed while the block is held in reset.

Top module: `cache_tag_dir`

## Requirements
- R1: The set index is address bits [OFF+SETB-1:OFF], where OFF = log2(BLOCK_BYTES) and SETB = log2(SETS). The stored tag is the full address with those low OFF+SETB bits cleared. Offset bits never affect a lookup.
- R2: A lookup hits only when a valid way of the indexed set holds an equal tag, and `rsp_way` names that way. Sets are independent of each other.
- R3: On a miss the lowest-numbered invalid way of the set is filled. The way is valid from the next access onward, so the same line then hits.
- R4: With `policy_sel` = 0 (LRU; encoding 3 behaves the same), every hit and every fill stamps the way with the set's generation count, which then increments. A full-set miss evicts the way with the smallest stamp, with ties going to the lowest index.
- R5: With `policy_sel` = 1 (FIFO), a full-set miss evicts the way filled longest ago. Hits do not change this order.
- R6: With `policy_sel` = 2 (random), a full-set miss evicts the way given by a 16-bit maximal-length LFSR modulo WAYS. Successive victims vary, and the filled line hits on its next access.
- R7: `access_count` increments once for every accepted request. `miss_count` increments once for every miss, and never exceeds `access_count`.
- R8: The response appears on the cycle after acceptance, with `rsp_valid` high for exactly that one cycle. `req_ready` is high whenever reset is low.
- R9: Synchronous reset clears all valid bits, replacement state and both counters, holds `rsp_valid` and `req_ready` low, and makes previously cached lines miss afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 2 | Replacement policy: 0 LRU, 1 FIFO, 2 random, 3 LRU |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_valid | output | 1 | Result valid, one cycle after acceptance |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | log2(WAYS) | Way that hit or was filled |
| access_count | output | CNT_W | Accepted requests since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
The hardest cases to reach are the full-set misses, because the victim then depends on the history of the set. To force a particular LRU victim, the bench first fills all eight ways of one set in order. It then re-touches selected ways so that the stamps no longer follow fill order, and checks each later eviction against the stamps worked out by hand. The FIFO run repeats the fill-then-hit pattern to show that hits leave the eviction order alone. A random victim cannot be predicted from the ports. For that policy, the bench re-accesses each new line at once to confirm the reported way, and checks that several different ways were chosen.

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int ADDR_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int WAYS        = 8,
  parameter int SETS        = 32,
  parameter int STAMP_W     = 32,
  parameter int CNT_W       = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                policy_sel,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [$clog2(WAYS)-1:0]   rsp_way,
  output logic [CNT_W-1:0]          access_count,
  output logic [CNT_W-1:0]          miss_count
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << (OFF_W + SET_W);
  localparam logic [1:0] POL_FIFO = 2'd1;
  localparam logic [1:0] POL_RAND = 2'd2;

  logic [ADDR_W-1:0]  tag_q   [SETS][WAYS];
  logic [STAMP_W-1:0] stamp_q [SETS][WAYS];
  logic [STAMP_W-1:0] gen_q   [SETS];
  logic [WAY_W-1:0]   fifo_q  [SETS];
  logic [WAYS-1:0]    vld_q   [SETS];
  logic [15:0]        lfsr_q;

  logic               acc;
  logic [SET_W-1:0]   set_idx;
  logic [ADDR_W-1:0]  tag_in;
  logic               hit, inv_any;
  logic [WAY_W-1:0]   hit_way, inv_way, lru_way, victim, sel_way;
  logic [STAMP_W-1:0] lru_min;

  assign req_ready = ~rst;
  assign acc       = req_valid & req_ready;
  assign set_idx   = req_addr[OFF_W +: SET_W];
  assign tag_in    = req_addr & TAG_MASK;

  always_comb begin
    hit = 1'b0; hit_way = '0; inv_any = 1'b0; inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[set_idx][w] && tag_q[set_idx][w] == tag_in) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!vld_q[set_idx][w]) begin
        inv_any = 1'b1; inv_way = WAY_W'(w);
      end
    end
    lru_way = '0;
    lru_min = stamp_q[set_idx][0];
    for (int w = 1; w < WAYS; w++) begin
      if (stamp_q[set_idx][w] < lru_min) begin
        lru_min = stamp_q[set_idx][w]; lru_way = WAY_W'(w);
      end
    end
    case (policy_sel)
      POL_FIFO: victim = fifo_q[set_idx];
      POL_RAND: victim = WAY_W'(lfsr_q % 16'(WAYS));
      default:  victim = lru_way;
    endcase
    sel_way = hit ? hit_way : (inv_any ? inv_way : victim);
  end

  always_ff @(posedge clk) begin
    if (acc && !hit) tag_q[set_idx][sel_way] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        gen_q[s]  <= '0;
        fifo_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) stamp_q[s][w] <= '0;
      end
      lfsr_q       <= 16'hACE1;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      access_count <= '0;
      miss_count   <= '0;
    end else begin
      lfsr_q    <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
      rsp_valid <= acc;
      if (acc) begin
        rsp_hit      <= hit;
        rsp_way      <= sel_way;
        access_count <= access_count + CNT_W'(1);
        stamp_q[set_idx][sel_way] <= gen_q[set_idx];
        gen_q[set_idx]            <= gen_q[set_idx] + STAMP_W'(1);
        if (!hit) begin
          miss_count <= miss_count + CNT_W'(1);
          vld_q[set_idx][sel_way] <= 1'b1;
          if (!inv_any && policy_sel == POL_FIFO)
            fifo_q[set_idx] <= (fifo_q[set_idx] == WAY_W'(WAYS - 1)) ? '0
                               : fifo_q[set_idx] + WAY_W'(1);
        end
      end
    end
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    acc |=> rsp_valid); // R8
  AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !rsp_valid); // R8
  AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (rst)
    acc |=> access_count == $past(access_count) + CNT_W'(1)); // R7
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> miss_count == $past(miss_count) + CNT_W'(1)); // R7
  AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> $stable(miss_count)); // R7
  AST_MISS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    miss_count <= access_count); // R7
endmodule

// File: tb/cache_tag_dir_test.sv
module cache_tag_dir_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  policy_sel = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_way;
  logic [31:0] access_count, miss_count;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cache_tag_dir uut (
    .clk(clk), .rst(rst), .policy_sel(policy_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .access_count(access_count),
    .miss_count(miss_count));

  // {req id, address, expected hit, expected way}; set 3 => base 192, tag t => t*2048
  localparam logic [39:0] VEC [15] = '{
    {4'd3, 32'(1*2048+192), 1'b0, 3'd0}, {4'd3, 32'(2*2048+192), 1'b0, 3'd1},
    {4'd3, 32'(3*2048+192), 1'b0, 3'd2}, {4'd3, 32'(4*2048+192), 1'b0, 3'd3},
    {4'd3, 32'(5*2048+192), 1'b0, 3'd4}, {4'd3, 32'(6*2048+192), 1'b0, 3'd5},
    {4'd3, 32'(7*2048+192), 1'b0, 3'd6}, {4'd3, 32'(8*2048+192), 1'b0, 3'd7},
    {4'd1, 32'(1*2048+192+5), 1'b1, 3'd0}, // R1 offset ignored
    {4'd2, 32'(3*2048+192), 1'b1, 3'd2},
    {4'd4, 32'(9*2048+192), 1'b0, 3'd1},   // R4 smallest stamp after reorder
    {4'd4, 32'(10*2048+192), 1'b0, 3'd3},
    {4'd4, 32'(2*2048+192), 1'b0, 3'd4},
    {4'd2, 32'(9*2048+192), 1'b1, 3'd1},
    {4'd2, 32'(1*2048+256), 1'b0, 3'd0}    // R2 other set independent
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, output logic h, output logic [2:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 rsp_valid", 64'(rsp_valid), 64'd1);
    h = rsp_hit; w = rsp_way;
  endtask

  task automatic expect_acc(input string req, input logic [31:0] a,
                            input logic eh, input logic [2:0] ew);
    logic h; logic [2:0] w;
    acc(a, h, w);
    chk(req, {h, w}, {eh, ew});
  endtask

  task automatic do_reset(input logic [1:0] pol);
    rst = 1'b1; policy_sel = pol;
    repeat (3) @(negedge clk);
    chk("R9 ready low in reset", 64'(req_ready), 64'd0);
    chk("R9 counters cleared", {access_count, miss_count}, 64'd0);
    chk("R9 rsp_valid low", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 ready after reset", 64'(req_ready), 64'd1);
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic h; logic [2:0] w; logic [7:0] seen;
    do_reset(2'd0);
    // LRU table covers R1, R2, R3, R4
    for (int i = 0; i < 15; i++) begin
      logic hh; logic [2:0] ww;
      acc(VEC[i][35:4], hh, ww);
      checks++;
      if ({hh, ww} !== VEC[i][3:0]) begin
        errors++;
        $display("FAIL R%0d row %0d actual=%0h expected=%0h", VEC[i][39:36], i,
                 {hh, ww}, VEC[i][3:0]);
      end
    end
    @(negedge clk);
    chk("R8 single-cycle response", 64'(rsp_valid), 64'd0);
    chk("R7 access count", 64'(access_count), 64'd15);
    chk("R7 miss count", 64'(miss_count), 64'd12);

    do_reset(2'd0);
    expect_acc("R9 line lost after reset", 32'(1*2048+192), 1'b0, 3'd0);

    // FIFO in set 5 (base 320)
    do_reset(2'd1);
    for (int t = 1; t <= 8; t++) expect_acc("R3 fill order", 32'(t*2048+320), 1'b0, 3'(t-1));
    expect_acc("R5 hit", 32'(1*2048+320), 1'b1, 3'd0);
    expect_acc("R5 hit", 32'(2*2048+320), 1'b1, 3'd1);
    expect_acc("R5 oldest evicted", 32'(9*2048+320), 1'b0, 3'd0);
    expect_acc("R5 next oldest", 32'(10*2048+320), 1'b0, 3'd1);
    expect_acc("R5 evicted line refills", 32'(1*2048+320), 1'b0, 3'd2);
    expect_acc("R5 untouched line", 32'(4*2048+320), 1'b1, 3'd3);
    expect_acc("R5 hit did not reorder", 32'(3*2048+320), 1'b0, 3'd3);

    // Random in set 7 (base 448)
    do_reset(2'd2);
    for (int t = 1; t <= 8; t++) expect_acc("R3 fill before random", 32'(t*2048+448), 1'b0, 3'(t-1));
    seen = '0;
    for (int t = 100; t < 120; t++) begin
      acc(32'(t*2048+448), h, w);
      chk("R6 random miss", 64'(h), 64'd0);
      seen[w] = 1'b1;
      expect_acc("R6 filled line hits", 32'(t*2048+448), 1'b1, w);
    end
    chk("R6 victims vary", 64'($countones(seen) >= 2), 64'd1);
    chk("R7 random counts", {access_count, miss_count}, {32'd48, 32'd28});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule